// File: doc/BRIEF.md
# Boundary Scan Pin Register Chain

This block is the boundary scan data register that sits beside the pad ring of a chip. It carries a serial chain of test cells: three for each bidirectional pad (input, output, output enable), one for each input-only or output-only pin, two fixed cells for the test-output pin, and a closing marker cell. The test access port controller and the instruction decoder are outside the block. They supply the test clock, the capture, shift and update state decodes, the serial input, and a select that hands the pads over to the chain.

Every cell has two stages. The capture/shift stage loads pin values in capture and forms the shift path in shift. The update stage holds what was last shifted in, and shifting does not change it. While the pad-test select is set, the pads are driven from the update stages instead of the core. This lets a board tester set pin levels and read them back through the serial port.

Top module: `bsr_chain`

## Requirements
- R1: Chain length is 3 + 3*NUM_BIDI + NUM_IN + NUM_OUT. Bit 0 is the test-output enable cell and bit 1 is the test-output data cell. Bidirectional pad p holds input at 2+3p, output at 3+3p and enable at 4+3p. Then come the input-only cells, then the output-only cells. The last bit is the update marker.
- R2: On a rising tck_i with capture_dr_i high, every cell samples its pin in the same cycle. Input cells take the pad input. Output and enable cells take the value presented to the pad. The test-output cells take tout_oe_i and tout_d_i.
- R3: The update-marker cell always captures 1.
- R4: On each rising tck_i with shift_dr_i high, the chain moves one bit toward tdo_o. tdi_i enters the last bit and tdo_o shows bit 0.
- R5: On a rising tck_i with update_dr_i high, every update stage loads its cell's capture/shift stage.
- R6: Update stages keep their value in every cycle without update_dr_i, including during capture and shift.
- R7: With extest_i high, pad_out_o, pad_oe_o and pad_only_o come from the update stages. With extest_i low, they follow core_out_i, core_oe_i and core_only_i.
- R8: Reset (rst_ni low) clears all stages to 0. An enable value of 0 means high impedance, so no pad is enabled after reset.
- R9: tout_oe_o, tout_d_o and upd_mark_o always show their update stages, whatever the mode. Input-only pins are captured only and drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| capture_dr_i | input | 1 | Capture-DR state decode |
| shift_dr_i | input | 1 | Shift-DR state decode |
| update_dr_i | input | 1 | Update-DR state decode |
| extest_i | input | 1 | Pads driven from chain |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0) |
| tout_oe_i | input | 1 | Observed test-output enable |
| tout_d_i | input | 1 | Observed test-output data |
| tout_oe_o | output | 1 | Test-output enable update stage |
| tout_d_o | output | 1 | Test-output data update stage |
| pad_in_i | input | NUM_BIDI | Pad input values |
| core_out_i | input | NUM_BIDI | Core output data |
| core_oe_i | input | NUM_BIDI | Core output enables |
| pad_out_o | output | NUM_BIDI | Output data to pads |
| pad_oe_o | output | NUM_BIDI | Output enables to pads |
| in_only_i | input | NUM_IN | Input-only pin values |
| core_only_i | input | NUM_OUT | Core data for output-only pins |
| pad_only_o | output | NUM_OUT | Output-only pin values |
| upd_mark_o | output | 1 | Update-marker update stage |

## Verification
The first capture runs in functional mode with a mixed pattern on the core and pad inputs. The shifted-out word must show the core values at the output and enable positions, which confirms that the cell order matches the index map. The second capture runs under pad test after an update. It must return the update-stage values rather than the core ones, which separates capture of the pad side from capture of the core side. A third load is shifted with no capture in between, and the word that comes out must equal the word shifted in before it. This exposes off-by-one errors in the shift path. Pad outputs are read again after that shift, before the update, which shows that shifting does not reach the update stages.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef struct packed {
    logic cap;
    logic shift;
    logic upd;
  } bsr_ctl_t;

  function automatic int chain_len(input int nb, input int ni, input int no);
    return 3 + 3 * nb + ni + no;
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  bsr_ctl_t ctl_i,
  input  logic     cap_i,
  input  logic     si_i,
  output logic     so_o,
  output logic     upd_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         so_o <= 1'b0;
    else if (ctl_i.cap)   so_o <= cap_i;
    else if (ctl_i.shift) so_o <= si_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        upd_o <= 1'b0;
    else if (ctl_i.upd) upd_o <= so_o;
  end

  // R6
  upd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !ctl_i.upd |=> $stable(upd_o));
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
  parameter int W = 1
) (
  input  logic         extest_i,
  input  logic [W-1:0] core_i,
  input  logic [W-1:0] upd_i,
  output logic [W-1:0] pad_o
);
  always_comb pad_o = extest_i ? upd_i : core_i;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int NUM_BIDI = 4,
  parameter int NUM_IN   = 2,
  parameter int NUM_OUT  = 2
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                capture_dr_i,
  input  logic                shift_dr_i,
  input  logic                update_dr_i,
  input  logic                extest_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic                tout_oe_i,
  input  logic                tout_d_i,
  output logic                tout_oe_o,
  output logic                tout_d_o,
  input  logic [NUM_BIDI-1:0] pad_in_i,
  input  logic [NUM_BIDI-1:0] core_out_i,
  input  logic [NUM_BIDI-1:0] core_oe_i,
  output logic [NUM_BIDI-1:0] pad_out_o,
  output logic [NUM_BIDI-1:0] pad_oe_o,
  input  logic [NUM_IN-1:0]   in_only_i,
  input  logic [NUM_OUT-1:0]  core_only_i,
  output logic [NUM_OUT-1:0]  pad_only_o,
  output logic                upd_mark_o
);
  localparam int L        = chain_len(NUM_BIDI, NUM_IN, NUM_OUT);
  localparam int PAD_BASE = 2;
  localparam int IN_BASE  = PAD_BASE + 3 * NUM_BIDI;
  localparam int OUT_BASE = IN_BASE + NUM_IN;

  bsr_ctl_t ctl;
  logic [L-1:0] cap_vec, so_vec, upd_vec;
  logic [NUM_BIDI-1:0] upd_out, upd_oe, upd_unused_in;
  logic [NUM_OUT-1:0]  upd_only;
  logic [NUM_IN-1:0]   upd_unused_ionly;
  logic                unused_upd;

  assign ctl = '{cap: capture_dr_i, shift: shift_dr_i, upd: update_dr_i};

  always_comb begin
    cap_vec    = '0;
    cap_vec[0] = tout_oe_i;
    cap_vec[1] = tout_d_i;
    for (int p = 0; p < NUM_BIDI; p++) begin
      cap_vec[PAD_BASE + 3*p]     = pad_in_i[p];
      cap_vec[PAD_BASE + 3*p + 1] = pad_out_o[p];
      cap_vec[PAD_BASE + 3*p + 2] = pad_oe_o[p];
    end
    for (int k = 0; k < NUM_IN; k++)  cap_vec[IN_BASE + k]  = in_only_i[k];
    for (int k = 0; k < NUM_OUT; k++) cap_vec[OUT_BASE + k] = pad_only_o[k];
    cap_vec[L-1] = 1'b1;
  end

  for (genvar i = 0; i < L; i++) begin : g_cell
    logic si;
    if (i == L - 1) begin : g_head
      assign si = tdi_i;
    end else begin : g_link
      assign si = so_vec[i+1];
    end
    bsr_cell u_cell (
      .tck_i (tck_i),
      .rst_ni(rst_ni),
      .ctl_i (ctl),
      .cap_i (cap_vec[i]),
      .si_i  (si),
      .so_o  (so_vec[i]),
      .upd_o (upd_vec[i])
    );
  end

  for (genvar p = 0; p < NUM_BIDI; p++) begin : g_pad
    assign upd_unused_in[p] = upd_vec[PAD_BASE + 3*p];
    assign upd_out[p]       = upd_vec[PAD_BASE + 3*p + 1];
    assign upd_oe[p]        = upd_vec[PAD_BASE + 3*p + 2];
  end
  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    assign upd_unused_ionly[k] = upd_vec[IN_BASE + k];
  end
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign upd_only[k] = upd_vec[OUT_BASE + k];
  end
  assign unused_upd = ^{upd_unused_in, upd_unused_ionly};

  bsr_pad_mux #(.W(NUM_BIDI)) u_out_mux (
    .extest_i(extest_i), .core_i(core_out_i), .upd_i(upd_out), .pad_o(pad_out_o));
  bsr_pad_mux #(.W(NUM_BIDI)) u_oe_mux (
    .extest_i(extest_i), .core_i(core_oe_i), .upd_i(upd_oe), .pad_o(pad_oe_o));
  bsr_pad_mux #(.W(NUM_OUT)) u_only_mux (
    .extest_i(extest_i), .core_i(core_only_i), .upd_i(upd_only), .pad_o(pad_only_o));

  assign tdo_o      = so_vec[0];
  assign tout_oe_o  = upd_vec[0];
  assign tout_d_o   = upd_vec[1];
  assign upd_mark_o = upd_vec[L-1];

  // R4
  shift_step_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_dr_i && !capture_dr_i) |=> tdo_o == $past(so_vec[1]));

  // R3
  marker_cap_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i |=> so_vec[L-1]);

  // R7
  core_oe_pass_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !extest_i |-> pad_oe_o == core_oe_i);

  // R5
  upd_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_dr_i |=> upd_mark_o == $past(so_vec[L-1]));
endmodule

// File: tb/sim_bsr_chain.sv
module sim_bsr_chain;
  localparam int NB = 4, NI = 2, NO = 2;
  localparam int L  = 3 + 3*NB + NI + NO;
  localparam int IB = 2 + 3*NB;
  localparam int OB = IB + NI;

  logic clk = 0, rst_n = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, extest = 0, tdi = 0;
  logic tdo, tout_oe, tout_d, tout_oe_q, tout_d_q, upd_mark;
  logic [NB-1:0] pad_in = '0, core_out = '0, core_oe = '0, pad_out, pad_oe;
  logic [NI-1:0] in_only = '0;
  logic [NO-1:0] core_only = '0, pad_only;

  int checks = 0, errors = 0;
  bit exp_q[$];
  logic [L-1:0] sr_m = '0, upd_m = '0;

  always #4 clk = ~clk;

  bsr_chain #(.NUM_BIDI(NB), .NUM_IN(NI), .NUM_OUT(NO)) u0 (
    .tck_i(clk), .rst_ni(rst_n), .capture_dr_i(capture_dr), .shift_dr_i(shift_dr),
    .update_dr_i(update_dr), .extest_i(extest), .tdi_i(tdi), .tdo_o(tdo),
    .tout_oe_i(tout_oe), .tout_d_i(tout_d), .tout_oe_o(tout_oe_q), .tout_d_o(tout_d_q),
    .pad_in_i(pad_in), .core_out_i(core_out), .core_oe_i(core_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .in_only_i(in_only),
    .core_only_i(core_only), .pad_only_o(pad_only), .upd_mark_o(upd_mark));

  initial begin tout_oe = 0; tout_d = 0; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one serial bit per shift cycle
  always @(negedge clk) begin
    if (rst_n && shift_dr) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected shift", {31'd0, tdo}, 32'd0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(tdo === e, "R1/R2/R4 serial bit", {31'd0, tdo}, {31'd0, e});
      end
    end
  end

  function automatic logic [L-1:0] cap_model();
    logic [L-1:0] v;
    v = '0;
    v[0] = tout_oe; v[1] = tout_d;
    for (int p = 0; p < NB; p++) begin
      v[2+3*p] = pad_in[p];
      v[3+3*p] = extest ? upd_m[3+3*p] : core_out[p];
      v[4+3*p] = extest ? upd_m[4+3*p] : core_oe[p];
    end
    for (int k = 0; k < NI; k++) v[IB+k] = in_only[k];
    for (int k = 0; k < NO; k++) v[OB+k] = extest ? upd_m[OB+k] : core_only[k];
    v[L-1] = 1'b1; // R3
    return v;
  endfunction

  task automatic do_capture();
    sr_m = cap_model();
    capture_dr = 1; @(posedge clk); #1; capture_dr = 0;
  endtask

  task automatic do_shift(input logic [L-1:0] vin);
    for (int i = 0; i < L; i++) begin
      tdi = vin[i]; shift_dr = 1; exp_q.push_back(sr_m[i]);
      @(posedge clk); #1;
    end
    shift_dr = 0;
    sr_m = vin;
  endtask

  task automatic do_update();
    update_dr = 1; @(posedge clk); #1; update_dr = 0;
    upd_m = sr_m;
  endtask

  task automatic check_pads(input string req);
    logic [NB-1:0] eo, ee;
    logic [NO-1:0] ey;
    for (int p = 0; p < NB; p++) begin
      eo[p] = extest ? upd_m[3+3*p] : core_out[p];
      ee[p] = extest ? upd_m[4+3*p] : core_oe[p];
    end
    for (int k = 0; k < NO; k++) ey[k] = extest ? upd_m[OB+k] : core_only[k];
    #1;
    chk(pad_out === eo, {req, " pad_out"}, 32'(pad_out), 32'(eo));
    chk(pad_oe === ee, {req, " pad_oe"}, 32'(pad_oe), 32'(ee));
    chk(pad_only === ey, {req, " pad_only"}, 32'(pad_only), 32'(ey));
    // R9
    chk({tout_oe_q, tout_d_q, upd_mark} === {upd_m[0], upd_m[1], upd_m[L-1]},
        {req, " R9 fixed cells"}, {29'd0, tout_oe_q, tout_d_q, upd_mark},
        {29'd0, upd_m[0], upd_m[1], upd_m[L-1]});
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    extest = 1; core_oe = '1; core_out = '1; core_only = '1;
    @(posedge clk); @(posedge clk); #1;
    // R8: reset state with pads handed to the chain
    check_pads("R8 reset");
    chk(tdo === 1'b0, "R8 tdo", {31'd0, tdo}, 32'd0);
    rst_n = 1; @(posedge clk); #1;
    extest = 0;
    check_pads("R7 core path");

    // pattern A, functional-mode capture (R1, R2, R3)
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b1100;
    in_only = 2'b01; core_only = 2'b10; tout_oe = 1; tout_d = 0;
    do_capture();
    do_shift(19'h5A3C6);
    do_update();              // R5
    check_pads("R5/R7 no extest");
    extest = 1;
    check_pads("R5/R7 extest");

    // pattern B, capture under extest returns update values (R2)
    core_out = 4'b0101; core_oe = 4'b1001; pad_in = 4'b0011;
    in_only = 2'b10; tout_oe = 0; tout_d = 1;
    do_capture();
    do_shift(19'h2B1E9);
    check_pads("R6 after shift");
    do_update();
    check_pads("R5 second load");

    // pure shift: previous word comes back out (R4), update untouched (R6)
    do_shift(19'h7FFFF);
    check_pads("R6 shift only");
    do_shift(19'h00001);
    do_update();
    check_pads("R5 walking one");
    in_only = 2'b11;          // R9: input-only change drives nothing
    check_pads("R9 input-only");
    extest = 0;
    check_pads("R7 release");

    @(posedge clk); #1;
    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule